// File: doc/BRIEF.md
# UTOPIA Level 2 Multi-Port Transmit Slave

This block sits on the receiving side of a UTOPIA Level 2 transmit bus. It works at cell level in multi-port mode, and each port reports its status on its own line. Up to four logical ports share one 8-bit octet bus. The bus master drives the start-of-cell marker, an active-low enable and a 5-bit address. The block works out which port the master has chosen. It passes every accepted octet to that port's cell buffer as a one-hot write strobe, together with the octet and first and last markers. From the free-space count of each port it drives one cell-available line per port.

The master chooses a port by pulling the enable high and placing an address on the bus. On the edge where the enable is low again, the block takes that address as the choice. The block answers only to the addresses from a base value up to the base plus the number of ports minus one. Each cell-available line is always valid, so the master reads port status without any address cycle. Octets are counted against a cell size that is fixed by configuration. The count produces the last-octet marker and tells the status logic how much of the current cell is still to come.

Top module: `utx_mphy_slave`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `tx_clav` and `wr_en` are all zero. Reset also clears the port selection to none and the octet count to zero.
- R2: A selection happens on a clock edge where `tx_enb_n` is 0 and was 1 at the previous edge. The first low edge after reset also counts. The port offset is `(tx_addr - cfg_base) mod 32`, and it is a valid port when it is below NPORT. The octet on that same edge goes to that port. One cycle later `wr_en` has exactly bit `offset` set, and `wr_data` carries the octet.
- R3: An offset of NPORT or more selects no port. Every octet after it is dropped (`wr_en` stays 0) until the next selection. With a base of 30, address 1 selects port 3 and address 29 selects nothing.
- R4: While `tx_enb_n` stays low, `tx_addr` has no effect, and octets keep going to the port already selected.
- R5: A cycle with `tx_enb_n` high accepts no octet, gives `wr_en` = 0 one cycle later and leaves the octet count unchanged. A paused cell continues its count once the master selects the same port again.
- R6: `wr_first` is 1 on the octet that carried `tx_soc`, and that octet has index 0. Later octets have index 1, 2 and so on. `wr_last` is 1 on the octet with index `cfg_cell_size - 1`, after which the count returns to 0. The cell size lies between 16 and 128.
- R7: Back-to-back cells are handled. When `tx_soc` comes on the octet right after a last octet, with the enable held low, that octet is taken as the first octet of a new cell on the same port.
- R8: For a port with no cell in progress, `tx_clav[p]` is 1 exactly when its free count is at least `cfg_cell_size`. The output is registered, so it follows its inputs one cycle later.
- R9: For the selected port while a cell is partly written, `tx_clav[p]` is 1 only when the free count covers the remaining octets of the current cell plus a whole next cell. The remaining octets are the cell size minus the octets already taken. The line therefore drops well before the last four octets whenever the next cell cannot fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 5 | Address that answers as port 0 |
| cfg_cell_size | input | 8 | Octets per cell (16 to 128) |
| tx_data | input | 8 | Octet from the bus master |
| tx_soc | input | 1 | Marks the first octet of a cell |
| tx_enb_n | input | 1 | Active-low transfer enable |
| tx_addr | input | 5 | Port address, sampled when the enable falls |
| port_free | input | NPORT*FREE_W | Free octets of each port buffer, port p at bits p*FREE_W and up |
| tx_clav | output | NPORT | Per-port cell-available line |
| wr_en | output | NPORT | One-hot per-port buffer write strobe |
| wr_data | output | 8 | Octet being written |
| wr_first | output | 1 | Written octet is the first of its cell |
| wr_last | output | 1 | Written octet is the last of its cell |

## Verification
Every result leaves the block through one register. Write strobes, data and the first and last markers show up one edge after the octet that caused them. Cell-available lines follow the free counts and the block's own cell progress one edge later as well. The bench changes its inputs on the falling edge and reads the outputs on the next falling edge, so exactly one rising edge falls between the stimulus and the check. The free-count checks first hold the bus in a pause, which keeps the selection and the count fixed while the status line settles.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
package utx_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 8;
    localparam int CELL_W    = 8;
    localparam int MAX_PORTS = 4;
    localparam int PIDX_W    = 2;

    typedef logic [PIDX_W-1:0] port_idx_t;

    typedef struct packed {
        logic      valid;
        port_idx_t idx;
    } port_sel_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              first;
        logic              last;
    } octet_t;

    // Offset of an address from the base, modulo the address space.
    function automatic port_sel_t decode_port(input logic [ADDR_W-1:0] addr,
                                              input logic [ADDR_W-1:0] base,
                                              input int              nports);
        logic [ADDR_W-1:0] off;
        port_sel_t         r;
        off     = addr - base;
        r.valid = (int'(off) < nports);
        r.idx   = off[PIDX_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/utx_sel.sv
`timescale 1ns/1ps
module utx_sel
    import utx_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output port_sel_t         cur,
    output port_sel_t         held
);

    logic      enb_n_q;
    port_sel_t held_q;
    logic      start;

    // Falling enable: this edge picks a new port from the address bus.
    assign start = ~enb_n & enb_n_q;

    always_comb begin
        cur = start ? decode_port(addr, base, NPORT) : held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enb_n_q <= 1'b1;
            held_q  <= '0;
        end else begin
            enb_n_q <= enb_n;
            held_q  <= cur;
        end
    end

    assign held = held_q;

    // Selection only moves on an enable falling edge.
    p_hold_sel_r4: assert property (@(posedge clk) disable iff (rst)
        !(~enb_n & enb_n_q) |=> $stable(held_q));

endmodule

// File: rtl/utx_cellcnt.sv
`timescale 1ns/1ps
module utx_cellcnt
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              soc,
    input  logic [CELL_W-1:0] cell_size,
    output logic              first,
    output logic              last,
    output logic [CELL_W-1:0] cnt
);

    logic [CELL_W-1:0] cnt_q;
    logic [CELL_W-1:0] idx;

    always_comb begin
        idx   = soc ? '0 : cnt_q;
        first = soc;
        last  = (idx == cell_size - CELL_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (acc) begin
            cnt_q <= last ? '0 : idx + CELL_W'(1);
        end
    end

    assign cnt = cnt_q;

    p_cnt_below_size_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q < cell_size);

    p_pause_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(cnt_q));

endmodule

// File: rtl/utx_status.sv
`timescale 1ns/1ps
module utx_status
    import utx_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int FREE_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT*FREE_W-1:0] port_free,
    input  logic [CELL_W-1:0]       cell_size,
    input  port_sel_t               held,
    input  logic [CELL_W-1:0]       cnt,
    output logic [NPORT-1:0]        clav
);

    localparam int CMP_W = (FREE_W > CELL_W + 1) ? FREE_W + 1 : CELL_W + 2;

    logic [NPORT-1:0] clav_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic             busy;
        logic [CMP_W-1:0] need;
        logic [CMP_W-1:0] have;

        always_comb begin
            busy = held.valid && (held.idx == PIDX_W'(p)) && (cnt != '0);
            need = CMP_W'(cell_size)
                 + (busy ? (CMP_W'(cell_size) - CMP_W'(cnt)) : '0);
            have = CMP_W'(port_free[p*FREE_W +: FREE_W]);
        end

        always_ff @(posedge clk) begin
            if (rst) clav_q[p] <= 1'b0;
            else     clav_q[p] <= (have >= need);
        end

        // Announced room always covers at least one full cell.
        p_room_r8: assert property (@(posedge clk) disable iff (rst)
            clav_q[p] |-> ($past(have) >= CMP_W'(cell_size)));
    end

    assign clav = clav_q;

endmodule

// File: rtl/utx_mphy_slave.sv
`timescale 1ns/1ps
module utx_mphy_slave
    import utx_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int FREE_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       cfg_base,
    input  logic [CELL_W-1:0]       cfg_cell_size,
    input  logic [DATA_W-1:0]       tx_data,
    input  logic                    tx_soc,
    input  logic                    tx_enb_n,
    input  logic [ADDR_W-1:0]       tx_addr,
    input  logic [NPORT*FREE_W-1:0] port_free,
    output logic [NPORT-1:0]        tx_clav,
    output logic [NPORT-1:0]        wr_en,
    output logic [DATA_W-1:0]       wr_data,
    output logic                    wr_first,
    output logic                    wr_last
);

    port_sel_t         cur;
    port_sel_t         held;
    logic              acc;
    logic              first;
    logic              last;
    logic [CELL_W-1:0] cnt;
    logic [NPORT-1:0]  wr_en_q;
    octet_t            oct_q;

    utx_sel #(.NPORT(NPORT)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .enb_n (tx_enb_n),
        .addr  (tx_addr),
        .base  (cfg_base),
        .cur   (cur),
        .held  (held)
    );

    assign acc = ~tx_enb_n & cur.valid;

    utx_cellcnt u_cnt (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .soc       (tx_soc),
        .cell_size (cfg_cell_size),
        .first     (first),
        .last      (last),
        .cnt       (cnt)
    );

    utx_status #(.NPORT(NPORT), .FREE_W(FREE_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .port_free (port_free),
        .cell_size (cfg_cell_size),
        .held      (held),
        .cnt       (cnt),
        .clav      (tx_clav)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_q <= '0;
            oct_q   <= '0;
        end else begin
            wr_en_q <= acc ? (NPORT'(1) << cur.idx) : '0;
            oct_q   <= '{data: tx_data, first: first, last: last};
        end
    end

    assign wr_en    = wr_en_q;
    assign wr_data  = oct_q.data;
    assign wr_first = oct_q.first;
    assign wr_last  = oct_q.last;

    p_one_port_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en_q));

    p_write_needs_enb_r5: assert property (@(posedge clk) disable iff (rst)
        (|wr_en_q) |-> $past(!tx_enb_n));

    p_first_from_soc_r6: assert property (@(posedge clk) disable iff (rst)
        ((|wr_en_q) && oct_q.first) |-> $past(tx_soc));

endmodule

// File: tb/utx_mphy_slave_tb.sv
`timescale 1ns/1ps
module utx_mphy_slave_tb;

    localparam int NPORT  = 4;
    localparam int FREE_W = 10;

    typedef struct packed {
        logic [4:0] addr;
        logic [3:0] exp_en;
    } sel_vec_t;

    // Base 6: ports answer at addresses 6..9.
    localparam sel_vec_t VEC [8] = '{
        '{addr: 5'd6,  exp_en: 4'b0001},
        '{addr: 5'd7,  exp_en: 4'b0010},
        '{addr: 5'd9,  exp_en: 4'b1000},
        '{addr: 5'd8,  exp_en: 4'b0100},
        '{addr: 5'd10, exp_en: 4'b0000},
        '{addr: 5'd5,  exp_en: 4'b0000},
        '{addr: 5'd31, exp_en: 4'b0000},
        '{addr: 5'd0,  exp_en: 4'b0000}
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [4:0]              cfg_base = 5'd6;
    logic [7:0]              cfg_cell_size = 8'd16;
    logic [7:0]              tx_data = '0;
    logic                    tx_soc = 1'b0;
    logic                    tx_enb_n = 1'b1;
    logic [4:0]              tx_addr = '0;
    logic [NPORT*FREE_W-1:0] port_free;
    logic [NPORT-1:0]        tx_clav;
    logic [NPORT-1:0]        wr_en;
    logic [7:0]              wr_data;
    logic                    wr_first;
    logic                    wr_last;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    utx_mphy_slave #(.NPORT(NPORT), .FREE_W(FREE_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .cfg_base      (cfg_base),
        .cfg_cell_size (cfg_cell_size),
        .tx_data       (tx_data),
        .tx_soc        (tx_soc),
        .tx_enb_n      (tx_enb_n),
        .tx_addr       (tx_addr),
        .port_free     (port_free),
        .tx_clav       (tx_clav),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .wr_first      (wr_first),
        .wr_last       (wr_last)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_free(input int p, input int v);
        port_free[p*FREE_W +: FREE_W] = FREE_W'(v);
    endtask

    // Drive one bus cycle, let one rising edge pass, return at the falling edge.
    task automatic bus(input logic enb_n, input logic [4:0] addr,
                       input logic soc, input logic [7:0] data);
        tx_enb_n = enb_n;
        tx_addr  = addr;
        tx_soc   = soc;
        tx_data  = data;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus(1'b1, 5'd0, 1'b0, 8'h00);
        bus(1'b1, 5'd0, 1'b0, 8'h00);
        rst = 1'b0;
    endtask

    initial begin
        for (int p = 0; p < NPORT; p++) set_free(p, 200);
        @(negedge clk);
        bus(1'b1, 5'd0, 1'b0, 8'h00);
        bus(1'b1, 5'd0, 1'b0, 8'h00);
        check("R1 clav in reset", 32'(tx_clav), 32'h0);
        check("R1 wr_en in reset", 32'(wr_en), 32'h0);
        rst = 1'b0;
        bus(1'b1, 5'd0, 1'b0, 8'h00);
        check("R8 clav idle with room", 32'(tx_clav), 32'hF);

        // Table walk: select, pause checks, and address ignored while low.
        for (int i = 0; i < 8; i++) begin
            bus(1'b1, VEC[i].addr, 1'b0, 8'h00);
            check("R5 no write with enable high", 32'(wr_en), 32'h0);
            bus(1'b0, VEC[i].addr, 1'b0, 8'hA0 + 8'(i));
            check("R2/R3 strobe after select", 32'(wr_en), 32'(VEC[i].exp_en));
            if (VEC[i].exp_en != 4'b0000)
                check("R2 data passed", 32'(wr_data), 32'(8'hA0 + 8'(i)));
            bus(1'b0, VEC[i].addr + 5'd1, 1'b0, 8'h55);
            check("R4 address ignored while low", 32'(wr_en), 32'(VEC[i].exp_en));
        end

        // Full cell then back-to-back cell on port 2 (address 8).
        do_reset();
        bus(1'b1, 5'd8, 1'b0, 8'h00);
        for (int i = 0; i < 16; i++) begin
            bus(1'b0, (i == 0) ? 5'd8 : 5'd31, i == 0, 8'(i));
            check("R6 cell strobe", 32'(wr_en), 32'h4);
            check("R6 cell data", 32'(wr_data), 32'(i));
            check("R6 first flag", 32'(wr_first), 32'(i == 0));
            check("R6 last flag", 32'(wr_last), 32'(i == 15));
        end
        for (int i = 0; i < 16; i++) begin
            bus(1'b0, 5'd31, i == 0, 8'(16 + i));
            check("R7 back-to-back strobe", 32'(wr_en), 32'h4);
            check("R7 back-to-back first", 32'(wr_first), 32'(i == 0));
            check("R7 back-to-back last", 32'(wr_last), 32'(i == 15));
        end

        // Paused cell on port 1 (address 7) with mid-cell status.
        bus(1'b1, 5'd7, 1'b0, 8'h00);
        for (int i = 0; i < 5; i++) begin
            bus(1'b0, 5'd7, i == 0, 8'(i));
            check("R6 flags before pause", 32'(wr_last), 32'h0);
        end
        bus(1'b1, 5'd7, 1'b0, 8'h00);
        check("R5 paused no write", 32'(wr_en), 32'h0);
        set_free(1, 26);
        bus(1'b1, 5'd7, 1'b0, 8'h00);
        check("R9 clav low when rest plus next cell does not fit", 32'(tx_clav[1]), 32'h0);
        check("R8 other idle port unaffected", 32'(tx_clav[0]), 32'h1);
        set_free(1, 27);
        bus(1'b1, 5'd7, 1'b0, 8'h00);
        check("R9 clav high when rest plus next cell fits", 32'(tx_clav[1]), 32'h1);
        set_free(1, 200);
        for (int i = 5; i < 16; i++) begin
            bus(1'b0, 5'd7, 1'b0, 8'(i));
            check("R5 resumed strobe", 32'(wr_en), 32'h2);
            check("R5 count kept across pause", 32'(wr_last), 32'(i == 15));
        end

        // Idle status threshold on port 3.
        set_free(3, 15);
        bus(1'b1, 5'd0, 1'b0, 8'h00);
        check("R8 clav low below one cell", 32'(tx_clav[3]), 32'h0);
        set_free(3, 16);
        bus(1'b1, 5'd0, 1'b0, 8'h00);
        check("R8 clav high at exactly one cell", 32'(tx_clav[3]), 32'h1);

        // Address wrap with base 30.
        cfg_base = 5'd30;
        do_reset();
        bus(1'b0, 5'd1, 1'b1, 8'h11);
        check("R3 wrapped address selects port 3", 32'(wr_en), 32'h8);
        bus(1'b1, 5'd29, 1'b0, 8'h00);
        bus(1'b0, 5'd29, 1'b0, 8'h22);
        check("R3 address below base selects nothing", 32'(wr_en), 32'h0);
        bus(1'b0, 5'd1, 1'b0, 8'h33);
        check("R3 octets dropped until next select", 32'(wr_en), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule